// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block connects a 32-bit processor core to a single-port, 32-bit-wide RAM. The RAM has one write enable for each byte lane and returns read data one clock after it sees the address. For a store, the core supplies a byte address, an access size and right-justified data. The block turns these into a RAM word address, a byte-lane write mask and data moved into the lanes being written. A mask of all zeros means the RAM does not write. Reads are always enabled.

For a load, the block records the low address bits, the size and the extension mode on the request cycle. On the next cycle it takes the addressed lanes from the word the RAM returns, moves them down to bit 0 and extends them to 32 bits. A small two-state machine tracks whether a load response is due. `LD_IDLE` goes to `LD_RESP` when an aligned load request is accepted. `LD_RESP` stays in `LD_RESP` when another aligned load arrives in that same cycle, and otherwise returns to `LD_IDLE`. A misaligned request raises a flag in the cycle it is presented, and that request neither writes nor produces a load result.

Top module: `lane_aligner`

## Requirements
- R1: `ram_addr` always equals bits [11:2] of `req_addr`, in the same cycle, for loads and stores alike.
- R2: Size encoding is 00 = byte, 01 = halfword, 10 = dword, 11 = reserved. For a valid aligned store, `ram_wmask` bit i is set exactly for the lanes being written. A byte store at offset k sets only bit k. A halfword store sets 0011 at offset 0 and 1100 at offset 2. A dword store sets 1111. In every other case (no request, a load, or a misaligned request) the mask is 0000.
- R3: For a store, `ram_wdata` holds the low 8, 16 or 32 bits of `req_wdata`, shifted left by 8 × (address bits [1:0]). All bits outside the written lanes are zero. For example, a halfword store of 0xFFFE to byte address 0x222 gives word address 0x88, mask 1100 and data 0xFFFE0000.
- R4: `misalign` is high in the same cycle as a valid request that is one of the following: a halfword with address bit 0 set, a dword with address bits [1:0] not equal to 00, or the reserved size code. Whenever `misalign` is high, the write mask is 0000.
- R5: `ld_valid` is high for exactly the cycle after an aligned load request. A misaligned load produces no `ld_valid`.
- R6: A load result uses the offset and size captured on the request cycle, not the inputs present on the response cycle. The selected byte or halfword is moved down to bit 0, and a dword is passed through unchanged.
- R7: When `req_sext` = 1, a byte or halfword result is sign-extended from its top bit. When `req_sext` = 0, it is zero-extended. `req_sext` has no effect on a dword load.
- R8: Aligned loads on consecutive cycles each produce a result on their own following cycle, so `ld_valid` stays high across back-to-back loads.
- R9: While `rst_n` is low and after it is released, `ld_valid` is 0 and `ld_data` is 0 until an aligned load request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 12 | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 dword, 11 reserved |
| req_sext | input | 1 | Load extension: 1 = sign, 0 = zero |
| req_wdata | input | 32 | Right-justified store data |
| ram_addr | output | 10 | RAM word address |
| ram_wmask | output | 4 | Byte-lane write enables |
| ram_wdata | output | 32 | Lane-shifted write data |
| ram_rdata | input | 32 | RAM read word, valid one cycle after the address |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Aligned, extended load result |
| misalign | output | 1 | Misaligned or reserved-size request |

## Verification
The only internal state is the load-response register together with the captured offset, size and extension mode. A fault in any of them appears at the ports in the cycle straight after a load request. A stuck or wrong state shows as a missing or extra `ld_valid` pulse. A wrong captured field shows as bytes taken from the wrong lane or extended the wrong way in `ld_data`. The bench therefore changes the request inputs on the response cycle, so that a design reading live inputs instead of the captured ones gives a different result. Store outputs are combinational and are checked in the same cycle as the request.

// File: rtl/lane_pkg.sv
package lane_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_RESP = 1'b1
    } ld_state_e;
endpackage

// File: rtl/lane_misalign_chk.sv
module lane_misalign_chk
    import lane_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic [OFF_W-1:0] off,
    input  acc_size_e        size,
    output logic             bad
);
    always_comb begin
        unique case (size)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = off[0];
            SZ_WORD: bad = |off;
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/lane_store_gen.sv
module lane_store_gen
    import lane_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              en,
    input  logic [OFF_W-1:0]  off,
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  wmask,
    output logic [DATA_W-1:0] wlanes
);
    int                nbytes;
    logic [DATA_W-1:0] trimmed;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                nbytes  = 1;
                trimmed = {{(DATA_W-8){1'b0}}, wdata[7:0]};
            end
            SZ_HALF: begin
                nbytes  = 2;
                trimmed = {{(DATA_W-16){1'b0}}, wdata[15:0]};
            end
            default: begin
                nbytes  = LANES;
                trimmed = wdata;
            end
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wmask[i] = en && (i >= int'(off)) && (i < int'(off) + nbytes);
    end

    assign wlanes = en ? (trimmed << {off, 3'b000}) : '0;
endmodule

// File: rtl/lane_load_ext.sv
module lane_load_ext
    import lane_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]  off,
    input  acc_size_e         size,
    input  logic              sext,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] down;

    assign down = rdata >> {off, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){sext & down[7]}}, down[7:0]};
            SZ_HALF: result = {{(DATA_W-16){sext & down[15]}}, down[15:0]};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
    import lane_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int WADDR_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic               req_sext,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic [WADDR_W-1:0] ram_addr,
    output logic [LANES-1:0]   ram_wmask,
    output logic [DATA_W-1:0]  ram_wdata,
    input  logic [DATA_W-1:0]  ram_rdata,
    output logic               ld_valid,
    output logic [DATA_W-1:0]  ld_data,
    output logic               misalign
);
    acc_size_e        size_in;
    logic [OFF_W-1:0] off_in;
    logic             bad;
    logic             st_go;
    logic             ld_go;

    ld_state_e        state, state_nx;
    logic [OFF_W-1:0] cap_off;
    acc_size_e        cap_size;
    logic             cap_sext;
    logic [DATA_W-1:0] ext_word;

    assign size_in  = acc_size_e'(req_size);
    assign off_in   = req_addr[OFF_W-1:0];
    assign ram_addr = req_addr[ADDR_W-1:OFF_W];

    lane_misalign_chk #(.OFF_W(OFF_W)) u_mis (
        .off  (off_in),
        .size (size_in),
        .bad  (bad)
    );

    assign misalign = req_valid & bad;
    assign st_go    = req_valid & req_write & ~bad;
    assign ld_go    = req_valid & ~req_write & ~bad;

    lane_store_gen #(.DATA_W(DATA_W)) u_st (
        .en     (st_go),
        .off    (off_in),
        .size   (size_in),
        .wdata  (req_wdata),
        .wmask  (ram_wmask),
        .wlanes (ram_wdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LD_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        unique case (state)
            LD_IDLE: state_nx = ld_go ? LD_RESP : LD_IDLE;
            LD_RESP: state_nx = ld_go ? LD_RESP : LD_IDLE;
            default: state_nx = LD_IDLE;
        endcase
    end

    // Request fields captured for the response cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_off  <= '0;
            cap_size <= SZ_BYTE;
            cap_sext <= 1'b0;
        end else if (ld_go) begin
            cap_off  <= off_in;
            cap_size <= size_in;
            cap_sext <= req_sext;
        end
    end

    lane_load_ext #(.DATA_W(DATA_W)) u_ld (
        .off    (cap_off),
        .size   (cap_size),
        .sext   (cap_sext),
        .rdata  (ram_rdata),
        .result (ext_word)
    );

    // Output logic
    always_comb begin
        unique case (state)
            LD_RESP: begin
                ld_valid = 1'b1;
                ld_data  = ext_word;
            end
            default: begin
                ld_valid = 1'b0;
                ld_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/lane_aligner_chk.sv
module lane_aligner_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [1:0]       req_size,
    input logic             misalign,
    input logic [LANES-1:0] ram_wmask,
    input logic             ld_valid
);
    assert_nowrite_misalign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> ram_wmask == '0);

    assert_nowrite_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !req_write) |-> ram_wmask == '0);

    assert_byte_onelane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size == 2'b00) |-> $countones(ram_wmask) == 1);

    assert_ldvalid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !misalign) |=> ld_valid);

    assert_ldvalid_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(req_valid && !req_write && !misalign));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R9: assert (!ld_valid);
        end
    end
endmodule

bind lane_aligner lane_aligner_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .misalign  (misalign),
    .ram_wmask (ram_wmask),
    .ld_valid  (ld_valid)
);

// File: tb/lane_aligner_tb.sv
module lane_aligner_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_sext = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [9:0]  ram_addr;
    logic [3:0]  ram_wmask;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = '0;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic        misalign;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    lane_aligner dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_sext(req_sext), .req_wdata(req_wdata),
        .ram_addr(ram_addr), .ram_wmask(ram_wmask), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
        .misalign(misalign)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [1:0]  sz;
        logic        sx;
        logic [31:0] wd;
        logic [31:0] rd;
        logic [3:0]  emask;
        logic [31:0] eval;
        logic        emis;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h222, 2'd1, 1'b0, 32'h0000FFFE, 32'h0,        4'hC, 32'hFFFE0000, 1'b0},
        '{1'b1, 12'h001, 2'd0, 1'b0, 32'hFFFFFFAB, 32'h0,        4'h2, 32'h0000AB00, 1'b0},
        '{1'b1, 12'h003, 2'd0, 1'b0, 32'h0000005A, 32'h0,        4'h8, 32'h5A000000, 1'b0},
        '{1'b1, 12'h010, 2'd2, 1'b0, 32'h12345678, 32'h0,        4'hF, 32'h12345678, 1'b0},
        '{1'b1, 12'h000, 2'd1, 1'b0, 32'hDEADBEEF, 32'h0,        4'h3, 32'h0000BEEF, 1'b0},
        '{1'b1, 12'h223, 2'd1, 1'b0, 32'h0000FFFE, 32'h0,        4'h0, 32'h0,        1'b1},
        '{1'b1, 12'h012, 2'd2, 1'b0, 32'h12345678, 32'h0,        4'h0, 32'h0,        1'b1},
        '{1'b0, 12'h403, 2'd0, 1'b1, 32'h0,        32'h80112233, 4'h0, 32'hFFFFFF80, 1'b0},
        '{1'b0, 12'h403, 2'd0, 1'b0, 32'h0,        32'h80112233, 4'h0, 32'h00000080, 1'b0},
        '{1'b0, 12'hFFE, 2'd1, 1'b1, 32'h0,        32'h9ABC1234, 4'h0, 32'hFFFF9ABC, 1'b0},
        '{1'b0, 12'h100, 2'd1, 1'b0, 32'h0,        32'h9ABC8234, 4'h0, 32'h00008234, 1'b0},
        '{1'b0, 12'h004, 2'd2, 1'b1, 32'h0,        32'hCAFEF00D, 4'h0, 32'hCAFEF00D, 1'b0},
        '{1'b0, 12'h001, 2'd0, 1'b1, 32'h0,        32'h00007F00, 4'h0, 32'h0000007F, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                         input logic sx, input logic [31:0] wd);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_size  = sz;
        req_sext  = sx;
        req_wdata = wd;
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9: reset state
        #2;
        check("R9 ld_valid in reset", {31'b0, ld_valid}, 32'h0);
        check("R9 ld_data in reset", ld_data, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R9 ld_valid after reset", {31'b0, ld_valid}, 32'h0);
        check("R2 idle mask", {28'b0, ram_wmask}, 32'h0);

        // Table walk: R1 R2 R3 R4 for stores, R5 R6 R7 for loads
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].wr, VECS[i].addr, VECS[i].sz, VECS[i].sx, VECS[i].wd);
            #1;
            check("R1 word address", {22'b0, ram_addr}, {22'b0, VECS[i].addr[11:2]});
            check("R2 write mask", {28'b0, ram_wmask}, {28'b0, VECS[i].emask});
            check("R4 misalign", {31'b0, misalign}, {31'b0, VECS[i].emis});
            if (VECS[i].wr && !VECS[i].emis) begin
                check("R3 lane data", ram_wdata, VECS[i].eval);
            end
            if (!VECS[i].wr) begin
                @(negedge clk);
                // scramble live inputs so only captured fields can give the right answer (R6)
                drive(1'b1, ~VECS[i].addr, ~VECS[i].sz, ~VECS[i].sx, 32'h0);
                req_valid = 1'b0;
                ram_rdata = VECS[i].rd;
                #1;
                check("R5 ld_valid pulse", {31'b0, ld_valid}, 32'h1);
                check("R6 R7 load result", ld_data, VECS[i].eval);
            end
            else begin
                @(negedge clk);
                req_valid = 1'b0;
                #1;
                check("R5 no pulse after store", {31'b0, ld_valid}, 32'h0);
            end
        end

        // R5: pulse lasts one cycle
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R5 pulse is single", {31'b0, ld_valid}, 32'h0);

        // R5: misaligned load gives no pulse
        @(negedge clk);
        drive(1'b0, 12'h005, 2'd1, 1'b0, 32'h0);
        #1;
        check("R4 misaligned load flag", {31'b0, misalign}, 32'h1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R5 misaligned load no pulse", {31'b0, ld_valid}, 32'h0);

        // R4: reserved size flagged, no write
        @(negedge clk);
        drive(1'b1, 12'h000, 2'd3, 1'b0, 32'hFFFFFFFF);
        #1;
        check("R4 reserved size flag", {31'b0, misalign}, 32'h1);
        check("R4 reserved size mask", {28'b0, ram_wmask}, 32'h0);

        // R2: store with req_valid low writes nothing
        @(negedge clk);
        drive(1'b1, 12'h000, 2'd2, 1'b0, 32'hFFFFFFFF);
        req_valid = 1'b0;
        #1;
        check("R2 no request mask", {28'b0, ram_wmask}, 32'h0);
        check("R4 no request flag", {31'b0, misalign}, 32'h0);

        // R8: back-to-back loads
        @(negedge clk);
        drive(1'b0, 12'h002, 2'd0, 1'b0, 32'h0);
        @(negedge clk);
        drive(1'b0, 12'h002, 2'd1, 1'b1, 32'h0);
        ram_rdata = 32'h8899AABB;
        #1;
        check("R8 first valid", {31'b0, ld_valid}, 32'h1);
        check("R8 first data", ld_data, 32'h00000099);
        @(negedge clk);
        req_valid = 1'b0;
        ram_rdata = 32'h8899AABB;
        #1;
        check("R8 second valid", {31'b0, ld_valid}, 32'h1);
        check("R8 second data", ld_data, 32'hFFFF8899);
        @(negedge clk);
        #1;
        check("R8 ends", {31'b0, ld_valid}, 32'h0);

        // R9: reset in the middle of a pending response
        @(negedge clk);
        drive(1'b0, 12'h000, 2'd2, 1'b0, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R9 reset clears response", {31'b0, ld_valid}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R9 idle after reset", {31'b0, ld_valid}, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule